// File: doc/BRIEF.md
# Unaligned Access Splitter

This block sits between a load/store unit and a word-wide memory port. It accepts one request at a time. A request can be a byte, a halfword or a word at any byte address. The block turns it into one or two aligned 32-bit beats, and each beat carries byte strobes. If an access crosses a word boundary, the block issues the lower word first and the next word second. For stores, the write data is spread over the byte lanes of both beats. For loads, the returned bytes are gathered in little-endian order into a right-justified, zero-extended result.

Some access classes cannot be split: exclusive, stack and bit-band accesses. A request of one of these classes carries a marker bit. If such a request is misaligned, the block returns a fault response and never touches the memory port. The memory port uses a valid/ready handshake. Read data is taken in the cycle a read beat is accepted.

Top module: `misalign_split`

## Requirements
- R1: Size codes are req_size 0 = byte, 1 = halfword, 2 or 3 = word. A byte at any offset, a halfword at an even offset and a word at offset 0 each take exactly one beat. That beat goes to the word-aligned address, and mem_strb has a 1 in bit k for each byte lane k the access covers.
- R2: A word at offset 1, 2 or 3 takes two beats. The first goes to the word holding the start address, with strobes on lanes offset..3. The second goes to that address plus 4, with strobes on lanes 0..offset-1.
- R3: A halfword at offset 1 takes a single beat with mem_strb = 4'b0110. A halfword at offset 3 takes two beats, with mem_strb 4'b1000 and then 4'b0001.
- R4: A load returns the accessed bytes in rsp_rdata. The byte at the lowest address goes in bits 7:0 and the following bytes go in ascending lanes. All bits above the access size are zero.
- R5: A store puts byte i of req_wdata (bits 8i+7:8i) in the byte lane for start address + i. It strobes only those lanes, so memory bytes outside the access keep their values.
- R6: A marked request (req_lock = 1) that is misaligned is answered with rsp_valid and rsp_fault one cycle after acceptance. It issues no memory beat and changes no memory byte. Misaligned here means an odd halfword or a word at a non-zero offset.
- R7: A marked request that is aligned behaves like an unmarked one and returns rsp_fault = 0.
- R8: req_ready is high in idle. It is low from the cycle after a request is accepted up to and including the response cycle.
- R9: rsp_valid is a single-cycle pulse one cycle after the last beat is accepted. While mem_ready is low, the pending beat holds its address, strobes and data.
- R10: The address of the second beat wraps modulo 2^ADDR_W. A word at 0xFFFFFFFE goes to 0xFFFFFFFC and then to 0x00000000.
- R11: After reset, req_ready = 1, mem_valid = 0 and rsp_valid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data, right-justified |
| req_lock | input | 1 | Access must not be split |
| mem_valid | output | 1 | Beat present on memory port |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_write | output | 1 | Beat is a write |
| mem_addr | output | ADDR_W | Word-aligned beat address |
| mem_strb | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Lane-positioned write data |
| mem_rdata | input | 32 | Read data, valid with the accepted read beat |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Misaligned marked access |
| rsp_rdata | output | 32 | Load result, zero for stores and faults |

## Verification
The bench targets every word and halfword offset and checks the beat count, the order of the two beat addresses and the per-beat strobes. A design that got the boundary test wrong would either split the halfword at offset 1 or fail to split the one at offset 3. Stores are checked by reading back the neighbouring words: an over-wide strobe would corrupt bytes outside the access. Loads are checked bytewise, which exposes a reversed lane order or missing zero-extension. Further tests run misaligned marked stores and loads and check that no beat appears and memory is unchanged. Back-pressure on the memory port and the top-of-address wrap catch a beat that moves while stalled and a second address that overflows the wrong way.

// File: rtl/misalign_split.sv
module misalign_split #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic              req_lock,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_strb,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [31:0]       rsp_rdata
);

  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI, S_RSP} st_t;

  st_t               st;
  logic              r_write;
  logic [1:0]        r_size;
  logic [1:0]        r_off;
  logic [ADDR_W-1:0] r_base;
  logic [31:0]       r_wdata;
  logic              r_fault;
  logic [63:0]       rbuf;

  logic [3:0]  len_mask;
  logic [7:0]  strb8;
  logic [63:0] wide_w;
  logic [63:0] shifted;
  logic [31:0] byte_keep;
  logic        crosses;
  logic        take;
  logic        misal;

  always_comb begin
    case (r_size)
      2'd0:    len_mask = 4'b0001;
      2'd1:    len_mask = 4'b0011;
      default: len_mask = 4'b1111;
    endcase
  end

  assign strb8     = {4'b0000, len_mask} << r_off;
  assign wide_w    = {32'd0, r_wdata} << {r_off, 3'b000};
  assign crosses   = |strb8[7:4];
  assign shifted   = rbuf >> {r_off, 3'b000};
  assign byte_keep = {{8{len_mask[3]}}, {8{len_mask[2]}}, {8{len_mask[1]}}, {8{len_mask[0]}}};

  assign take  = req_valid && req_ready;
  assign misal = (req_size == 2'd1 && req_addr[0]) ||
                 (req_size[1] && req_addr[1:0] != 2'b00);

  assign req_ready = (st == S_IDLE);
  assign mem_valid = (st == S_LO) || (st == S_HI);
  assign mem_write = r_write;
  assign mem_addr  = (st == S_HI) ? r_base + WORD_STEP : r_base;
  assign mem_strb  = (st == S_HI) ? strb8[7:4] : strb8[3:0];
  assign mem_wdata = (st == S_HI) ? wide_w[63:32] : wide_w[31:0];

  assign rsp_valid = (st == S_RSP);
  assign rsp_fault = (st == S_RSP) && r_fault;
  assign rsp_rdata = (st == S_RSP && !r_write && !r_fault) ? (shifted[31:0] & byte_keep) : 32'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      r_write <= 1'b0;
      r_size  <= 2'd0;
      r_off   <= 2'd0;
      r_base  <= '0;
      r_wdata <= 32'd0;
      r_fault <= 1'b0;
      rbuf    <= 64'd0;
    end else begin
      case (st)
        S_IDLE: if (take) begin
          r_write <= req_write;
          r_size  <= req_size;
          r_off   <= req_addr[1:0];
          r_base  <= {req_addr[ADDR_W-1:2], 2'b00};
          r_wdata <= req_wdata;
          r_fault <= req_lock && misal;
          rbuf    <= 64'd0;
          st      <= (req_lock && misal) ? S_RSP : S_LO;
        end
        S_LO: if (mem_ready) begin
          if (!r_write) rbuf[31:0] <= mem_rdata;
          st <= crosses ? S_HI : S_RSP;
        end
        S_HI: if (mem_ready) begin
          if (!r_write) rbuf[63:32] <= mem_rdata;
          st <= S_RSP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/misalign_split_chk.sv
module misalign_split_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_size,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_lock,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        mem_strb,
  input logic [31:0]       mem_wdata,
  input logic              rsp_valid,
  input logic              rsp_fault
);

  logic bad_lock;
  assign bad_lock = req_lock && ((req_size == 2'd1 && req_addr[0]) ||
                                 (req_size[1] && req_addr[1:0] != 2'b00));

  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  a_r9_stall_holds_beat: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_strb) && $stable(mem_wdata));

  a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r6_fault_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && bad_lock |=> rsp_valid && rsp_fault && !mem_valid);

  a_r7_no_fault_when_ok: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !bad_lock |=> !rsp_fault && mem_valid);

  a_r1_beat_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[1:0] == 2'b00 && mem_strb != 4'b0000);

  a_r8_no_beat_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_valid && !rsp_valid);

endmodule

bind misalign_split misalign_split_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_size(req_size), .req_addr(req_addr), .req_lock(req_lock),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .mem_strb(mem_strb), .mem_wdata(mem_wdata), .rsp_valid(rsp_valid),
  .rsp_fault(rsp_fault)
);

// File: tb/misalign_split_tb_top.sv
`timescale 1ns/1ps
module misalign_split_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = 32'd0;
  logic [31:0] req_wdata = 32'd0;
  logic        req_lock = 1'b0;
  logic        mem_valid;
  logic        mem_ready;
  logic        mem_write;
  logic [31:0] mem_addr;
  logic [3:0]  mem_strb;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [31:0] rsp_rdata;

  always #2 clk = ~clk;

  misalign_split #(.ADDR_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_lock(req_lock), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_strb(mem_strb), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata)
  );

  logic [31:0] mem [16];
  logic [7:0]  sh [64];
  logic        stall_en = 1'b0;
  logic        tog = 1'b0;
  int          nb = 0;
  logic [31:0] la [1024];
  logic [3:0]  ls [1024];
  int          n_chk = 0;
  int          n_fail = 0;

  assign mem_ready = !stall_en || tog;
  assign mem_rdata = mem[mem_addr[5:2]];

  always @(posedge clk) begin
    tog <= ~tog;
    if (mem_valid && mem_ready) begin
      la[nb % 1024] <= mem_addr;
      ls[nb % 1024] <= mem_strb;
      nb <= nb + 1;
      if (mem_write)
        for (int b = 0; b < 4; b++)
          if (mem_strb[b]) mem[mem_addr[5:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
    end
  end

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [3:0] exp_strb(input int off, input int n, input bit hi);
    logic [3:0] s = 4'b0000;
    for (int i = 0; i < n; i++) begin
      if (hi && off + i >= 4) s[off + i - 4] = 1'b1;
      if (!hi && off + i < 4) s[off + i] = 1'b1;
    end
    return s;
  endfunction

  task automatic issue(input bit wr, input logic [1:0] sz, input logic [31:0] a,
                       input logic [31:0] wd, input bit lk, input string rq,
                       output logic [31:0] rd, output bit flt, output int beats, output int first);
    int waitc = 0;
    bit busy_bad = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd; req_lock = lk;
    first = nb;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && waitc < 60) begin
      if (req_ready) busy_bad = 1;
      @(negedge clk);
      waitc++;
    end
    if (req_ready) busy_bad = 1;
    check(!busy_bad, "R8 ready low while busy", 32'(busy_bad), 32'd0);
    rd = rsp_rdata; flt = rsp_fault; beats = nb - first;
    @(negedge clk);
    check(!rsp_valid && req_ready, "R9 single response pulse", 32'(rsp_valid), 32'd0);
  endtask

  task automatic check_beats(input logic [1:0] sz, input logic [31:0] a, input int beats,
                             input int first, input string rq);
    int off = int'(a[1:0]);
    int n = nbytes(sz);
    int expb = (off + n > 4) ? 2 : 1;
    logic [31:0] base = {a[31:2], 2'b00};
    check(beats == expb, rq, 32'(beats), 32'(expb));
    if (beats >= 1) begin
      check(la[first % 1024] == base, rq, la[first % 1024], base);
      check(ls[first % 1024] == exp_strb(off, n, 0), rq, 32'(ls[first % 1024]), 32'(exp_strb(off, n, 0)));
    end
    if (beats == 2 && expb == 2) begin
      check(la[(first + 1) % 1024] == base + 32'd4, rq, la[(first + 1) % 1024], base + 32'd4);
      check(ls[(first + 1) % 1024] == exp_strb(off, n, 1), rq, 32'(ls[(first + 1) % 1024]), 32'(exp_strb(off, n, 1)));
    end
  endtask

  task automatic run_load(input logic [1:0] sz, input logic [31:0] a, input bit lk, input string rq);
    logic [31:0] rd, exp;
    bit flt;
    int beats, first;
    exp = 32'd0;
    for (int i = 0; i < nbytes(sz); i++) exp[8*i +: 8] = sh[(a + 32'(i)) & 32'd63];
    issue(1'b0, sz, a, 32'd0, lk, rq, rd, flt, beats, first);
    check(!flt, rq, 32'(flt), 32'd0);
    check(rd == exp, {rq, " R4 load data"}, rd, exp);
    check_beats(sz, a, beats, first, rq);
  endtask

  task automatic run_store(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] wd,
                           input bit lk, input string rq);
    logic [31:0] rd;
    bit flt;
    int beats, first;
    issue(1'b1, sz, a, wd, lk, rq, rd, flt, beats, first);
    check(!flt, rq, 32'(flt), 32'd0);
    check_beats(sz, a, beats, first, rq);
    for (int i = 0; i < nbytes(sz); i++) sh[(a + 32'(i)) & 32'd63] = wd[8*i +: 8];
  endtask

  task automatic readback_words(input string rq);
    for (int w = 0; w < 16; w++) run_load(2'd2, 32'(4 * w), 1'b0, rq);
  endtask

  task automatic t_reset;
    check(req_ready && !mem_valid && !rsp_valid, "R11 reset state",
          {29'd0, req_ready, mem_valid, rsp_valid}, 32'h4);
  endtask

  task automatic t_aligned;
    for (int o = 0; o < 4; o++) run_load(2'd0, 32'(16 + o), 1'b0, "R1 byte load");
    run_load(2'd1, 32'd20, 1'b0, "R1 half load off0");
    run_load(2'd1, 32'd22, 1'b0, "R1 half load off2");
    run_load(2'd2, 32'd24, 1'b0, "R1 word load off0");
    run_load(2'd3, 32'd28, 1'b0, "R1 word load size3");
  endtask

  task automatic t_word_split;
    for (int o = 1; o < 4; o++) run_load(2'd2, 32'(32 + o), 1'b0, "R2 word split load");
  endtask

  task automatic t_half_odd;
    run_load(2'd1, 32'd41, 1'b0, "R3 half off1 single beat");
    run_load(2'd1, 32'd43, 1'b0, "R3 half off3 split");
  endtask

  task automatic t_stores;
    run_store(2'd2, 32'd7,  32'hA1B2C3D4, 1'b0, "R5 word store off3");
    run_store(2'd2, 32'd13, 32'h11223344, 1'b0, "R5 word store off1");
    run_store(2'd1, 32'd49, 32'hFFFF5A6B, 1'b0, "R5 half store off1");
    run_store(2'd1, 32'd55, 32'hEEEE7C8D, 1'b0, "R5 half store off3");
    run_store(2'd0, 32'd62, 32'hCCCCCC9E, 1'b0, "R5 byte store");
    readback_words("R5 readback");
  endtask

  task automatic t_lock;
    logic [31:0] rd;
    bit flt;
    int beats, first;
    issue(1'b0, 2'd2, 32'd5, 32'd0, 1'b1, "R6", rd, flt, beats, first);
    check(flt, "R6 locked word fault", 32'(flt), 32'd1);
    check(beats == 0, "R6 no beat", 32'(beats), 32'd0);
    check(rd == 32'd0, "R6 fault data zero", rd, 32'd0);
    issue(1'b1, 2'd1, 32'd9, 32'hDEADBEEF, 1'b1, "R6", rd, flt, beats, first);
    check(flt, "R6 locked half store fault", 32'(flt), 32'd1);
    check(beats == 0, "R6 no beat store", 32'(beats), 32'd0);
    issue(1'b0, 2'd1, 32'd3, 32'd0, 1'b1, "R6", rd, flt, beats, first);
    check(flt && beats == 0, "R6 locked half off3", 32'(flt), 32'd1);
    readback_words("R6 memory unchanged");
    run_load(2'd2, 32'd36, 1'b1, "R7 locked aligned word");
    run_load(2'd1, 32'd38, 1'b1, "R7 locked aligned half");
    run_store(2'd0, 32'd45, 32'h00000077, 1'b1, "R7 locked byte store");
    run_load(2'd2, 32'd44, 1'b0, "R7 readback");
  endtask

  task automatic t_stall;
    stall_en = 1'b1;
    run_load(2'd2, 32'd18, 1'b0, "R9 stalled split load");
    run_store(2'd2, 32'd27, 32'h5566A7B8, 1'b0, "R9 stalled split store");
    run_load(2'd2, 32'd24, 1'b0, "R9 stalled readback lo");
    run_load(2'd2, 32'd28, 1'b0, "R9 stalled readback hi");
    stall_en = 1'b0;
  endtask

  task automatic t_wrap;
    run_load(2'd2, 32'hFFFFFFFE, 1'b0, "R10 wrap word");
    run_load(2'd1, 32'hFFFFFFFF, 1'b0, "R10 wrap half");
  endtask

  initial begin
    for (int k = 0; k < 64; k++) sh[k] = 8'((k * 37 + 5) % 256);
    for (int w = 0; w < 16; w++) mem[w] = {sh[4*w+3], sh[4*w+2], sh[4*w+1], sh[4*w]};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_aligned();
    t_word_split();
    t_half_odd();
    t_stores();
    t_lock();
    t_stall();
    t_wrap();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule